// File: doc/BRIEF.md
# Pulse-Width Packet Decoder

This block turns a sampled serial line into 48-bit packet words. A sample strobe from outside marks the moments at which the line is read. The block measures how many consecutive samples the line stays high. A one-sample pulse stands for a data 0 and a two-sample pulse for a data 1. A three-sample pulse is a frame marker that opens or closes a packet.

Data bits that arrive between an opening marker and a closing marker are shifted into a word. When the closing marker follows exactly 48 bits, the word is presented for one cycle with a valid strobe and a flag that reports odd parity. Over-long high pulses and over-long low gaps inside a frame abort the frame with an error strobe. A saturating counter reports how many packets have been delivered since reset.

Top module: `pulse_frame_decoder`

## Requirements
- R1: After reset `pkt_valid`, `pkt_par_err` and `frame_err` are low and `pkt_count` is zero.
- R2: A high pulse that lasts one sample is read as bit 0 and one that lasts two samples as bit 1. Bits fill the word MSB first, so the first bit after the opening marker ends up in `pkt_data[47]`.
- R3: A three-sample high pulse is a marker. While idle, a marker opens a frame. If exactly 48 bits have been collected when a marker arrives, `pkt_valid` is high for one cycle, the clock edge after the strobe that samples the low following the marker. The frame then closes.
- R4: A marker that arrives inside a frame with any bit count other than 48 discards the partial word and gives no strobe. The marker opens a new frame.
- R5: A fourth consecutive high sample raises `frame_err` for one cycle, inside or outside a frame. It also drops any partial word.
- R6: Inside a frame, a third consecutive low sample raises `frame_err` for one cycle and drops the partial word. Outside a frame, low runs of any length have no effect.
- R7: `pkt_par_err` is high together with `pkt_valid` exactly when the 48-bit word holds an odd number of ones. The word is still delivered.
- R8: `pkt_count` rises by one for each `pkt_valid`, whatever the parity result, and saturates at its all-ones value.
- R9: The line is read only on cycles with `samp_en` high. Line changes while `samp_en` is low have no effect.
- R10: Data pulses that arrive outside a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | Sample strobe; the line is read when high |
| line_in | input | 1 | Serial data line |
| pkt_data | output | PKT_BITS (48) | Last delivered packet word |
| pkt_valid | output | 1 | One-cycle strobe for a delivered packet |
| pkt_par_err | output | 1 | Odd parity on the delivered packet; only with `pkt_valid` |
| frame_err | output | 1 | One-cycle strobe when a frame is aborted by a long pulse or gap |
| pkt_count | output | CNT_W (16) | Saturating count of delivered packets |

## Verification
The hardest cases to reach are those where one marker both discards a short or over-long partial frame and opens the next. They are produced by sending a marker followed by too few or too many bits, then a complete packet that begins with its own marker; only that complete packet may come out. The line is inverted on every cycle where the strobe is low, so any sampling outside the strobe corrupts every packet. Counter saturation is reached by building the bench with a narrow counter and sending more packets than it can hold.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Pulse lengths in samples
    localparam int MARK_RUN = 3;
    localparam int LONG_RUN = MARK_RUN + 1;
    localparam int GAP_RUN  = 3;

    typedef enum logic {
        FR_IDLE   = 1'b0,
        FR_ACTIVE = 1'b1
    } fr_state_e;

    // Events from the run meter; at most one per sample
    typedef struct packed {
        logic zero;
        logic one;
        logic mark;
        logic long_hi;
        logic gap;
    } run_ev_t;

endpackage

// File: rtl/pfd_run_meter.sv
module pfd_run_meter
    import pfd_pkg::*;
#(
    parameter int MARK_LEN = MARK_RUN,
    parameter int GAP_LEN  = GAP_RUN
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    samp_en,
    input  logic    line_in,
    output run_ev_t ev_o
);

    localparam int LONG_LEN = MARK_LEN + 1;
    localparam int HI_W     = $clog2(LONG_LEN + 1);
    localparam int LO_W     = $clog2(GAP_LEN + 1);

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } meter_t;

    meter_t  meter_q, meter_d;
    run_ev_t ev;

    always_comb begin
        meter_d = meter_q;
        ev      = '0;
        if (samp_en) begin
            if (line_in) begin
                meter_d.lo = '0;
                if (meter_q.hi < HI_W'(LONG_LEN))
                    meter_d.hi = meter_q.hi + 1'b1;
                if (meter_q.hi == HI_W'(LONG_LEN - 1))
                    ev.long_hi = 1'b1;
            end else begin
                meter_d.hi = '0;
                if (meter_q.lo < LO_W'(GAP_LEN))
                    meter_d.lo = meter_q.lo + 1'b1;
                if (meter_q.lo == LO_W'(GAP_LEN - 1))
                    ev.gap = 1'b1;
                if (meter_q.hi == HI_W'(1))
                    ev.zero = 1'b1;
                else if (meter_q.hi == HI_W'(2))
                    ev.one = 1'b1;
                else if (meter_q.hi == HI_W'(MARK_LEN))
                    ev.mark = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meter_q.hi <= '0;
            meter_q.lo <= LO_W'(GAP_LEN);
        end else begin
            meter_q <= meter_d;
        end
    end

    assign ev_o = ev;

    // R2: a sample yields at most one classification event
    p_events_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_o));

    // R9: no event on a cycle without the sample strobe
    p_idle_strobe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |-> (ev_o == '0));

endmodule

// File: rtl/pfd_frame_asm.sv
module pfd_frame_asm
    import pfd_pkg::*;
#(
    parameter int PKT_BITS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  run_ev_t             ev_i,
    output logic [PKT_BITS-1:0] pkt_o,
    output logic                valid_o,
    output logic                par_err_o,
    output logic                frame_err_o
);

    localparam int BC_W   = $clog2(PKT_BITS + 2);
    localparam int BC_TOP = PKT_BITS + 1;

    typedef struct packed {
        fr_state_e           st;
        logic [PKT_BITS-1:0] sh;
        logic [BC_W-1:0]     bc;
        logic [PKT_BITS-1:0] pkt;
        logic                valid;
        logic                perr;
        logic                ferr;
    } asm_t;

    asm_t asm_q, asm_d;

    always_comb begin
        asm_d       = asm_q;
        asm_d.valid = 1'b0;
        asm_d.perr  = 1'b0;
        asm_d.ferr  = 1'b0;
        if (ev_i.long_hi) begin
            asm_d.ferr = 1'b1;
            asm_d.st   = FR_IDLE;
        end else if (ev_i.gap && asm_q.st == FR_ACTIVE) begin
            asm_d.ferr = 1'b1;
            asm_d.st   = FR_IDLE;
        end else if (ev_i.mark) begin
            if (asm_q.st == FR_ACTIVE && asm_q.bc == BC_W'(PKT_BITS)) begin
                asm_d.pkt   = asm_q.sh;
                asm_d.valid = 1'b1;
                asm_d.perr  = ^asm_q.sh;
                asm_d.st    = FR_IDLE;
            end else begin
                asm_d.st = FR_ACTIVE;
                asm_d.bc = '0;
            end
        end else if ((ev_i.zero || ev_i.one) && asm_q.st == FR_ACTIVE) begin
            asm_d.sh = {asm_q.sh[PKT_BITS-2:0], ev_i.one};
            if (asm_q.bc != BC_W'(BC_TOP))
                asm_d.bc = asm_q.bc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q.st    <= FR_IDLE;
            asm_q.sh    <= '0;
            asm_q.bc    <= '0;
            asm_q.pkt   <= '0;
            asm_q.valid <= 1'b0;
            asm_q.perr  <= 1'b0;
            asm_q.ferr  <= 1'b0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign pkt_o       = asm_q.pkt;
    assign valid_o     = asm_q.valid;
    assign par_err_o   = asm_q.perr;
    assign frame_err_o = asm_q.ferr;

    // R3: a delivered packet strobes for a single cycle
    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5: an abort and a delivery never coincide
    p_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && frame_err_o));

    // R4: the bit counter stays inside its range
    p_bc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        asm_q.bc <= BC_W'(BC_TOP));

    // R7: a parity flag appears only with a delivered packet
    p_perr_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> valid_o);

    // R3: a delivery leaves the assembler idle
    p_idle_after_pkt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> asm_q.st == FR_IDLE);

endmodule

// File: rtl/pfd_sat_counter.sv
module pfd_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_q, ctr_d;

    always_comb begin
        ctr_d = ctr_q;
        if (inc_i && ctr_q.cnt != CNT_MAX)
            ctr_d.cnt = ctr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctr_q.cnt <= '0;
        else
            ctr_q <= ctr_d;
    end

    assign cnt_o = ctr_q.cnt;

    // R8: a full counter holds its value
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));

    // R8: the count moves only on a packet strobe
    p_count_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_o));

endmodule

// File: rtl/pulse_frame_decoder.sv
module pulse_frame_decoder
    import pfd_pkg::*;
#(
    parameter int PKT_BITS = 48,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_en,
    input  logic                line_in,
    output logic [PKT_BITS-1:0] pkt_data,
    output logic                pkt_valid,
    output logic                pkt_par_err,
    output logic                frame_err,
    output logic [CNT_W-1:0]    pkt_count
);

    run_ev_t run_ev;

    pfd_run_meter #(
        .MARK_LEN (MARK_RUN),
        .GAP_LEN  (GAP_RUN)
    ) meter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_en (samp_en),
        .line_in (line_in),
        .ev_o    (run_ev)
    );

    pfd_frame_asm #(
        .PKT_BITS (PKT_BITS)
    ) asm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (run_ev),
        .pkt_o       (pkt_data),
        .valid_o     (pkt_valid),
        .par_err_o   (pkt_par_err),
        .frame_err_o (frame_err)
    );

    pfd_sat_counter #(
        .W (CNT_W)
    ) count_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (pkt_valid),
        .cnt_o (pkt_count)
    );

endmodule

// File: tb/pulse_frame_decoder_tb_top.sv
module pulse_frame_decoder_tb_top;

    localparam int PB = 48;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          samp_en = 1'b0;
    logic          line_in = 1'b0;
    logic [PB-1:0] pkt_data;
    logic          pkt_valid;
    logic          pkt_par_err;
    logic          frame_err;
    logic [CW-1:0] pkt_count;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    typedef struct packed {
        logic          is_err;
        logic [PB-1:0] data;
        logic          perr;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    pulse_frame_decoder #(.PKT_BITS(PB), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .line_in(line_in),
        .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_par_err(pkt_par_err),
        .frame_err(frame_err), .pkt_count(pkt_count)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One sample; the line is inverted on the off cycle (R9)
    task automatic put(input logic v);
        @(negedge clk); line_in = v; samp_en = 1'b1;
        @(negedge clk); samp_en = 1'b0; line_in = ~v;
    endtask

    task automatic send_bit(input logic b);
        put(1'b1);
        if (b) put(1'b1);
        put(1'b0);
        if (!b) put(1'b0);
    endtask

    task automatic send_mark();
        put(1'b1); put(1'b1); put(1'b1); put(1'b0);
    endtask

    task automatic idle(input int n);
        repeat (n) put(1'b0);
    endtask

    function automatic logic [PB-1:0] make_word(input int idx, input bit bad_par);
        logic [PB-1:0] w;
        w = {16'hA5C3 ^ 16'(idx * 7), 32'h1357_9BDF * 32'(idx + 3)};
        w[0] = (^w[PB-1:1]) ^ bad_par;
        return w;
    endfunction

    task automatic send_packet(input logic [PB-1:0] w);
        exp_t e;
        e.is_err = 1'b0; e.data = w; e.perr = ^w;
        exp_q.push_back(e);
        send_mark();
        for (int i = PB - 1; i >= 0; i--) send_bit(w[i]);
        send_mark();
        idle(4);
    endtask

    task automatic expect_err();
        exp_t e;
        e = '0; e.is_err = 1'b1;
        exp_q.push_back(e);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (pkt_valid || frame_err)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R6/R10 unexpected strobe", {62'b0, pkt_valid, frame_err}, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_err) begin
                    check(frame_err && !pkt_valid, "R5/R6 frame_err", {62'b0, pkt_valid, frame_err}, 64'h1);
                end else begin
                    check(pkt_valid && pkt_data == e.data, "R2/R3 packet word", 64'(pkt_data), 64'(e.data));
                    check(pkt_par_err == e.perr, "R7 parity flag", 64'(pkt_par_err), 64'(e.perr));
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!pkt_valid && !pkt_par_err && !frame_err, "R1 strobes low", {61'b0, pkt_valid, pkt_par_err, frame_err}, 64'h0);
        check(pkt_count == 0, "R1 count zero", 64'(pkt_count), 64'h0);
        rst_n = 1'b1;
        idle(3);

        // R2 R3 R7: good packet, then bad parity
        send_packet(make_word(1, 1'b0));
        send_packet(make_word(2, 1'b1));
        check(pkt_count == 2, "R8 count after two", 64'(pkt_count), 64'h2);

        // R4: short frame restarted by the next marker
        send_mark();
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        send_packet(make_word(3, 1'b0));

        // R4: 49 bits then a marker that opens a new frame
        send_mark();
        for (int i = 0; i < 49; i++) send_bit(i[1]);
        send_packet(make_word(4, 1'b0));

        // R5: long high pulse inside a frame
        expect_err();
        send_mark();
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        repeat (5) put(1'b1);
        idle(3);
        send_packet(make_word(5, 1'b1));

        // R6: long low gap inside a frame; long idle outside has no effect
        expect_err();
        send_mark();
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        idle(20);
        send_packet(make_word(6, 1'b0));

        // R10: data pulses outside a frame, R5 long high outside a frame
        for (int i = 0; i < 8; i++) send_bit(i[0]);
        idle(3);
        expect_err();
        repeat (4) put(1'b1);
        idle(3);
        send_packet(make_word(7, 1'b0));
        check(pkt_count == 7, "R8 count after seven", 64'(pkt_count), 64'h7);

        // R8: saturation of a 4-bit counter
        for (int k = 0; k < 10; k++) send_packet(make_word(10 + k, k[0]));
        check(pkt_count == 4'hF, "R8 saturated count", 64'(pkt_count), 64'hF);

        idle(4);
        check(exp_q.size() == 0, "R9 all expected items seen", 64'(exp_q.size()), 64'h0);
        finish_run();
    end

endmodule